// File: doc/BRIEF.md
# Accumulator One-Address Processor Core

This block is a small accumulator machine in which every instruction names at most one operand. It repeats a fixed three-step loop. First it fetches the word that the program counter points at. Then it bumps the program counter. Then it executes the instruction it fetched. Instructions and data share one word-addressed memory, reached through a synchronous port whose read data arrives one cycle after the request. The core keeps five architectural registers: the program counter, the instruction register, the address register, the accumulator and an operand register. Arithmetic fills the operand register from memory before it overwrites the accumulator.

Address 0 never reaches the memory for loads and stores. A load from address 0 takes one value from an input stream with a valid/ready handshake. A store to address 0 puts the accumulator onto an output stream. The core stalls for as long as the partner is not ready. Subroutine linkage has two parts: a branch that leaves a return address in the target word, and a branch that jumps through a memory word. After a halt the core freezes, and its registers stay visible on debug outputs until reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted and right after it is released, the program counter reads 1, `halted`, `div_err`, `out_valid` and `in_ready` are low, and the first memory read is issued to address 1.
- R2: An instruction word holds the opcode in bits 15:12 and the operand in bits 11:0. The opcodes are 0 halt, 1 add, 2 subtract, 3 multiply, 4 divide, 5 set, 6 negate, 7 increment, 8 decrement, 9 load, 10 store, 11 branch, 12 branch-if-zero, 13 branch-if-positive, 14 branch-and-store, 15 branch-indirect. A fetch copies the program counter into the address register and the fetched word into the instruction register, and the program counter advances by 1 before execution.
- R3: Add, subtract, multiply and divide first load the operand register from the word at the operand address. They then replace the accumulator with accumulator+B, accumulator−B, the low 16 bits of accumulator×B, or the signed quotient truncated toward zero.
- R4: A divide by a zero word leaves the accumulator unchanged and sets `div_err`, which stays set until reset.
- R5: Set loads the sign-extended 12-bit operand into the accumulator. Negate, increment and decrement change the accumulator in place, with wrap-around in two's complement.
- R6: Load and store with a non-zero address read and write that memory word.
- R7: A load from address 0 raises `in_ready` and waits until `in_valid`, then consumes exactly one input value. A store to address 0 presents the accumulator with `out_valid` and holds it steady until `out_ready`. Output values appear in program order.
- R8: Branch always loads the operand into the program counter. Branch-if-zero does so only when the accumulator is 0. Branch-if-positive does so only when the accumulator is greater than 0. Otherwise execution goes on at the incremented address.
- R9: Branch-and-store writes the incremented program counter into the word at the operand address and continues at operand+1. Branch-indirect continues at the address held in the word at the operand address.
- R10: Halt raises `halted`. From then on there are no memory accesses, and the registers stay frozen until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Read request, data returned the following cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after `mem_rd` |
| in_data | input | 16 | Input stream value |
| in_valid | input | 1 | Input stream value present |
| in_ready | output | 1 | Core waiting on an input value |
| out_data | output | 16 | Output stream value |
| out_valid | output | 1 | Output value present |
| out_ready | input | 1 | Output consumer accepts |
| halted | output | 1 | Core stopped by a halt |
| div_err | output | 1 | Sticky divide-by-zero flag |
| dbg_pc | output | 12 | Program counter |
| dbg_ir | output | 16 | Instruction register |
| dbg_ar | output | 12 | Address register |
| dbg_acc | output | 16 | Accumulator |
| dbg_b | output | 16 | Operand register |

## Verification
On an arithmetic instruction, two things happen in the same cycle: the operand register is filled from the returning memory word, and the accumulator is overwritten. The arithmetic unit takes the memory word directly, not the old operand register. Divide, multiply, subtract and add programs provoke this collision, and it is judged by the final accumulator and operand register values. A divide by zero adds the error flag to that same cycle. The input and output stalls are varied between runs, and a scoreboard queue compares every accepted output against the value the program should produce at that point.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   // Opcode values are architectural: program words depend on them.
   typedef enum logic [3:0] {
      OP_HLT = 4'd0,
      OP_ADD = 4'd1,
      OP_SUB = 4'd2,
      OP_MLT = 4'd3,
      OP_DIV = 4'd4,
      OP_SET = 4'd5,
      OP_NEG = 4'd6,
      OP_INC = 4'd7,
      OP_DEC = 4'd8,
      OP_LDA = 4'd9,
      OP_STA = 4'd10,
      OP_BR  = 4'd11,
      OP_BRZ = 4'd12,
      OP_BRP = 4'd13,
      OP_BRS = 4'd14,
      OP_BRI = 4'd15
   } opcode_e;

   typedef enum logic [2:0] {
      ST_FETCH,
      ST_FWAIT,
      ST_BUMP,
      ST_EXEC,
      ST_OPWAIT,
      ST_IN,
      ST_OUT,
      ST_HALT
   } state_e;

   function automatic logic is_arith(input opcode_e op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MLT) || (op == OP_DIV);
   endfunction

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  opcode_e           op,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] opnd,
   input  logic [DATA_W-1:0] imm,
   output logic [DATA_W-1:0] res,
   output logic              div_zero
);

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic signed [DATA_W-1:0] quot;

   always_comb begin
      quot = '0;
      if (opnd != '0) quot = $signed(acc) / $signed(opnd);
   end

   always_comb begin
      res      = acc;
      div_zero = 1'b0;
      case (op)
         OP_ADD: res = acc + opnd;
         OP_SUB: res = acc - opnd;
         OP_MLT: res = acc * opnd;
         OP_DIV: begin
            if (opnd == '0) div_zero = 1'b1;
            else            res = quot;
         end
         OP_SET: res = imm;
         OP_NEG: res = '0 - acc;
         OP_INC: res = acc + ONE;
         OP_DEC: res = acc - ONE;
         default: res = acc;
      endcase
   end

   // R4
   always_comb begin
      if (div_zero) begin
         div_keep_chk: assert (res == acc);
      end
   end

endmodule

// File: rtl/acc_cpu_branch.sv
module acc_cpu_branch
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  opcode_e           op,
   input  logic [DATA_W-1:0] acc,
   input  logic [ADDR_W-1:0] operand,
   output logic              take,
   output logic [ADDR_W-1:0] target
);

   logic acc_zero;
   logic acc_pos;

   assign acc_zero = (acc == '0);
   assign acc_pos  = !acc[DATA_W-1] && !acc_zero;

   always_comb begin
      take   = 1'b0;
      target = operand;
      case (op)
         OP_BR:  take = 1'b1;
         OP_BRZ: take = acc_zero;
         OP_BRP: take = acc_pos;
         OP_BRS: begin
            take   = 1'b1;
            target = operand + ADDR_W'(1);
         end
         default: take = 1'b0;
      endcase
   end

   // R8
   always_comb begin
      if (op == OP_BRP && take) begin
         brp_sign_chk: assert (!acc[DATA_W-1] && acc != '0);
      end
   end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int OPC_W    = 4,
   parameter int ADDR_W   = 12,
   parameter int START_PC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              halted,
   output logic              div_err,
   output logic [ADDR_W-1:0] dbg_pc,
   output logic [DATA_W-1:0] dbg_ir,
   output logic [ADDR_W-1:0] dbg_ar,
   output logic [DATA_W-1:0] dbg_acc,
   output logic [DATA_W-1:0] dbg_b
);

   localparam int EXT_W = DATA_W - ADDR_W;
   localparam logic [ADDR_W-1:0] PC_RST = ADDR_W'(START_PC);
   localparam logic [ADDR_W-1:0] IO_ADDR = '0;

   generate
      if (OPC_W != 4) begin : g_bad_opc
         $error("opcode field must be 4 bits for a 16-entry instruction set");
      end
      if (DATA_W != OPC_W + ADDR_W) begin : g_bad_split
         $error("word width must equal opcode width plus operand width");
      end
      if (START_PC < 1 || START_PC >= (1 << ADDR_W)) begin : g_bad_start
         $error("start address must be a non-zero address in range");
      end
   endgenerate

   state_e            state;
   logic [ADDR_W-1:0] pc;
   logic [DATA_W-1:0] ir;
   logic [ADDR_W-1:0] ar;
   logic [DATA_W-1:0] acc;
   logic [DATA_W-1:0] b;
   logic              err;

   opcode_e           op;
   logic [ADDR_W-1:0] operand;
   logic [DATA_W-1:0] imm_ext;
   logic              io_sel;
   logic [DATA_W-1:0] alu_opnd;
   logic [DATA_W-1:0] alu_res;
   logic              alu_dz;
   logic              br_take;
   logic [ADDR_W-1:0] br_target;

   assign op      = opcode_e'(ir[DATA_W-1 -: OPC_W]);
   assign operand = ir[ADDR_W-1:0];
   assign imm_ext = {{EXT_W{operand[ADDR_W-1]}}, operand};
   assign io_sel  = (operand == IO_ADDR);

   // In the data-return cycle the ALU takes the memory word directly.
   assign alu_opnd = (state == ST_OPWAIT) ? mem_rdata : b;

   acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
      .op       (op),
      .acc      (acc),
      .opnd     (alu_opnd),
      .imm      (imm_ext),
      .res      (alu_res),
      .div_zero (alu_dz)
   );

   acc_cpu_branch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_branch (
      .op      (op),
      .acc     (acc),
      .operand (operand),
      .take    (br_take),
      .target  (br_target)
   );

   // Memory and stream side
   always_comb begin
      mem_rd = 1'b0;
      mem_wr = 1'b0;
      if (state == ST_FETCH) begin
         mem_rd = 1'b1;
      end else if (state == ST_EXEC) begin
         mem_rd = is_arith(op) || (op == OP_BRI) || (op == OP_LDA && !io_sel);
         mem_wr = (op == OP_BRS) || (op == OP_STA && !io_sel);
      end
   end

   assign mem_addr  = (state == ST_FETCH) ? pc : operand;
   assign mem_wdata = (op == OP_BRS) ? {{EXT_W{1'b0}}, pc} : acc;
   assign in_ready  = (state == ST_IN);
   assign out_valid = (state == ST_OUT);
   assign out_data  = acc;
   assign halted    = (state == ST_HALT);
   assign div_err   = err;

   assign dbg_pc  = pc;
   assign dbg_ir  = ir;
   assign dbg_ar  = ar;
   assign dbg_acc = acc;
   assign dbg_b   = b;

   // Sequencer and register file
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_FETCH;
         pc    <= PC_RST;
         ir    <= '0;
         ar    <= '0;
         acc   <= '0;
         b     <= '0;
         err   <= 1'b0;
      end else begin
         case (state)
            ST_FETCH: begin
               ar    <= pc;
               state <= ST_FWAIT;
            end
            ST_FWAIT: begin
               ir    <= mem_rdata;
               state <= ST_BUMP;
            end
            ST_BUMP: begin
               pc    <= pc + ADDR_W'(1);
               state <= ST_EXEC;
            end
            ST_EXEC: begin
               case (op)
                  OP_HLT: state <= ST_HALT;
                  OP_ADD, OP_SUB, OP_MLT, OP_DIV, OP_BRI: begin
                     ar    <= operand;
                     state <= ST_OPWAIT;
                  end
                  OP_LDA: begin
                     ar    <= operand;
                     state <= io_sel ? ST_IN : ST_OPWAIT;
                  end
                  OP_STA: begin
                     ar    <= operand;
                     state <= io_sel ? ST_OUT : ST_FETCH;
                  end
                  OP_SET, OP_NEG, OP_INC, OP_DEC: begin
                     acc   <= alu_res;
                     state <= ST_FETCH;
                  end
                  OP_BRS: begin
                     ar    <= operand;
                     pc    <= br_target;
                     state <= ST_FETCH;
                  end
                  default: begin
                     if (br_take) pc <= br_target;
                     state <= ST_FETCH;
                  end
               endcase
            end
            ST_OPWAIT: begin
               if (is_arith(op)) begin
                  b   <= mem_rdata;
                  acc <= alu_res;
                  if (alu_dz) err <= 1'b1;
               end else if (op == OP_LDA) begin
                  acc <= mem_rdata;
               end else begin
                  pc <= mem_rdata[ADDR_W-1:0];
               end
               state <= ST_FETCH;
            end
            ST_IN: begin
               if (in_valid) begin
                  acc   <= in_data;
                  state <= ST_FETCH;
               end
            end
            ST_OUT: begin
               if (out_ready) state <= ST_FETCH;
            end
            default: state <= ST_HALT;
         endcase
      end
   end

   // R10
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted && $stable(dbg_pc) && $stable(dbg_acc));

   // R10
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_rd && !mem_wr);

   // R4
   div_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_err |=> div_err);

   // R7
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   // R7
   in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready && !in_valid |=> in_ready && $stable(dbg_acc));

   // R2
   mem_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

endmodule

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;
   logic [15:0] in_data = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] out_data;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic        halted, div_err;
   logic [11:0] dbg_pc, dbg_ar;
   logic [15:0] dbg_ir, dbg_acc, dbg_b;

   logic [15:0] mem [256];
   logic        ld_we = 1'b0;
   logic [7:0]  ld_addr = '0;
   logic [15:0] ld_data = '0;

   logic [15:0] exp_out [$];
   logic [15:0] in_q [$];
   int          io_mode = 0;
   int          cyc = 0;
   bit          pend = 0;
   int          nchk = 0;
   int          nfail = 0;

   always #10 clk = ~clk;

   acc_cpu u_acc_cpu (
      .clk(clk), .rst_n(rst_n),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
      .halted(halted), .div_err(div_err),
      .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_ar(dbg_ar),
      .dbg_acc(dbg_acc), .dbg_b(dbg_b)
   );

   always @(posedge clk) begin
      if (ld_we) mem[ld_addr] <= ld_data;
      else if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Stream driver and output monitor, all at the falling edge.
   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         pend      = 0;
         in_valid  = 1'b0;
         out_ready = 1'b0;
      end else begin
         if (pend) begin
            if (in_q.size() > 0) void'(in_q.pop_front());
            pend = 0;
         end
         in_valid = ((io_mode == 0) || (cyc % 4 == 1)) && (in_q.size() > 0);
         in_data  = (in_q.size() > 0) ? in_q[0] : 16'h0;
         if (in_valid && in_ready) pend = 1;
         out_ready = (io_mode == 0) || (cyc % 3 == 0);
         if (out_valid && out_ready) begin
            if (exp_out.size() == 0) check("R7 unexpected output", {16'h0, out_data}, 32'hdead);
            else check("R7 output value", {16'h0, out_data}, {16'h0, exp_out.pop_front()});
         end
      end
   end

   task automatic load(input logic [15:0] prog [$], input int base);
      foreach (prog[i]) begin
         @(negedge clk);
         ld_we = 1'b1; ld_addr = 8'(base + i); ld_data = prog[i];
      end
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   task automatic clear_mem();
      for (int a = 0; a < 256; a++) begin
         @(negedge clk);
         ld_we = 1'b1; ld_addr = 8'(a); ld_data = 16'h0;
      end
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   // Release reset, run to halt, then confirm the halt is permanent.
   task automatic run(input string name);
      int n = 0;
      logic [11:0] pc_h;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check({name, " R1 first fetch read"}, {31'h0, mem_rd}, 32'h1);
      check({name, " R1 first fetch addr"}, {20'h0, mem_addr}, 32'h1);
      while (!halted && n < 5000) begin
         @(negedge clk);
         n++;
      end
      check({name, " R10 halted"}, {31'h0, halted}, 32'h1);
      pc_h = dbg_pc;
      repeat (6) @(negedge clk);
      check({name, " R10 pc frozen"}, {20'h0, dbg_pc}, {20'h0, pc_h});
      check({name, " R7 all outputs seen"}, exp_out.size(), 0);
   endtask

   task automatic go_reset();
      @(negedge clk);
      rst_n = 1'b0;
      exp_out.delete();
      in_q.delete();
   endtask

   initial begin
      logic [15:0] p [$];

      // Reset state
      go_reset();
      @(negedge clk);
      check("R1 reset pc", {20'h0, dbg_pc}, 32'h1);
      check("R1 reset halted", {31'h0, halted}, 0);
      check("R1 reset div_err", {31'h0, div_err}, 0);
      check("R1 reset out_valid", {31'h0, out_valid}, 0);
      check("R1 reset in_ready", {31'h0, in_ready}, 0);

      // Program A: countdown with branch-if-positive (R5 R8), stalled output
      clear_mem();
      p = '{16'h5003, 16'hA000, 16'h8000, 16'hD002, 16'h0000};
      load(p, 1);
      exp_out = '{16'd3, 16'd2, 16'd1};
      io_mode = 1;
      run("A");
      check("A R8 acc", {16'h0, dbg_acc}, 32'h0);
      check("A R2 pc", {20'h0, dbg_pc}, 32'd6);
      check("A R2 ar", {20'h0, dbg_ar}, 32'd5);
      check("A R2 ir", {16'h0, dbg_ir}, 32'h0);
      check("A R4 no err", {31'h0, div_err}, 0);

      // Program B: (x+y)^2 with inputs, add and multiply (R3 R6 R7)
      go_reset();
      clear_mem();
      p = '{16'h9000, 16'hA064, 16'h9000, 16'h1064, 16'hA064, 16'h3064, 16'hA000, 16'h0000};
      load(p, 1);
      in_q    = '{16'd3, 16'd4};
      exp_out = '{16'd49};
      io_mode = 1;
      run("B");
      check("B R3 acc", {16'h0, dbg_acc}, 32'd49);
      check("B R3 b", {16'h0, dbg_b}, 32'd7);
      check("B R6 stored word", {16'h0, mem[100]}, 32'd7);
      check("B R7 inputs consumed", in_q.size(), 0);
      check("B R2 pc", {20'h0, dbg_pc}, 32'd9);

      // Program C: subroutine via branch-and-store and branch-indirect (R9)
      go_reset();
      clear_mem();
      p = '{16'h9000, 16'hE007, 16'hE007, 16'hE007, 16'hA000, 16'h0000,
            16'h0000, 16'h7000, 16'hF007};
      load(p, 1);
      in_q    = '{16'd10};
      exp_out = '{16'd13};
      io_mode = 0;
      run("C");
      check("C R9 acc", {16'h0, dbg_acc}, 32'd13);
      check("C R9 link word", {16'h0, mem[7]}, 32'd5);
      check("C R9 pc", {20'h0, dbg_pc}, 32'd7);
      check("C R2 ar", {20'h0, dbg_ar}, 32'd6);

      // Program D: signed divide, subtract, zero branch, negate, divide by zero
      go_reset();
      clear_mem();
      p = '{16'h5FF9, 16'h4014, 16'hA000, 16'h2015, 16'hC008, 16'hA000, 16'h0000,
            16'h7000, 16'h6000, 16'hA000, 16'hD007, 16'h4016, 16'hA000, 16'hC007,
            16'hB011, 16'hA000, 16'h0000};
      load(p, 1);
      p = '{16'h0002, 16'hFFFD, 16'h0000};
      load(p, 20);
      exp_out = '{16'hFFFD, 16'hFFFF, 16'hFFFF};
      io_mode = 1;
      run("D");
      check("D R4 acc kept", {16'h0, dbg_acc}, 32'hFFFF);
      check("D R4 div_err", {31'h0, div_err}, 32'h1);
      check("D R3 b zero word", {16'h0, dbg_b}, 32'h0);
      check("D R8 pc", {20'h0, dbg_pc}, 32'd18);
      check("D R2 ar", {20'h0, dbg_ar}, 32'd17);

      // Reset clears the sticky flag (R4)
      go_reset();
      @(negedge clk);
      check("R4 reset clears err", {31'h0, div_err}, 0);
      check("R1 pc after reset", {20'h0, dbg_pc}, 32'h1);

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule